// File: doc/BRIEF.md
# DMA Channel Descriptor and Auto-Reload Engine

This block keeps the per-channel control records of an eight-channel DMA controller up to date. The records sit in RAM as a table. Each channel owns a 32-byte slot, which holds four active words followed by four reload words. The engine keeps the table base in a register that the host programs over a small register port. It reaches the table through a word-wide memory port that uses a valid/ready handshake and allows one access in flight.

The data mover reports each finished transfer by pulsing `upd_req` with a channel number while `eng_idle` is high. The engine then works through these steps:

- It fetches word 0 of that channel's record.
- It takes one off the 12-bit transfer count and writes word 0 back. The reserved and low fields stay unchanged.
- It decides whether the channel has finished. A channel finishes when the count it consumed decoded to one transfer.
- If the channel has finished and its auto-reload enable bit is set, it copies the four reload words over the four active words.
- It pulses `upd_ack`. When the channel has finished, it raises `chan_done` in the same cycle.

Channel arbitration and data movement are handled outside this block.

States and transitions:

- IDLE goes to FETCH when a request is accepted.
- FETCH goes to WBACK when the word-0 read completes.
- WBACK goes to RL_RD when the write completes, the count was the last one and reload is enabled. Otherwise it goes to REPORT.
- RL_RD goes to RL_WR when a reload-word read completes.
- RL_WR goes back to RL_RD after words 0 to 2 have been written. After word 3 it goes to REPORT.
- REPORT always returns to IDLE.

Top module: `dma_desc_engine`

## Requirements
- R1: After reset, the register port reads 0x0008_0000 at register 0 (table base), 0 at register 1 (reload enables, bit n for channel n) and 0 at register 2 (busy flags, bit n for channel n). `eng_idle` is high.
- R2: Bits [9:0] of the table base read as zero whatever value is written. The remaining bits hold the written value.
- R3: For a request on channel c, the first access reads address base + 32·c. The second access writes that same address.
- R4: The word written back is the fetched word with its count field, bits [23:12], reduced by one. Bits [31:24] and [11:0] are unchanged.
- R5: A count field of 0x000 stands for 4096 transfers. It is written back as 0xFFF, and the channel does not finish.
- R6: A count field of 0x001 finishes the channel. `chan_done` is high in the `upd_ack` cycle and `done_ch` equals c. With reload disabled, no further memory access follows the write-back.
- R7: With reload enabled for a finishing channel, the engine performs four read/write pairs after the write-back, for k = 0 to 3 in order. Each pair reads base + 32·c + 16 + 4k and then writes the read value to base + 32·c + 4k. Only then does it signal `upd_ack` and `chan_done`.
- R8: A channel's busy flag is set when a request on that channel is accepted. It is cleared when that channel finishes. Register 2 is read-only.
- R9: In the `upd_ack` cycle, `src_ptr` equals bit 11 of the fetched word 0 (1 = pointer, 0 = data).
- R10: A request made while `eng_idle` is low is ignored and causes no memory access.
- R11: While `mem_req` is high and `mem_ready` is low, `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 base, 1 reload enables, 2 busy |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| upd_req | input | 1 | One-cycle pulse: a transfer finished on `upd_ch` |
| upd_ch | input | 3 | Channel number of the request |
| eng_idle | output | 1 | High when a request can be accepted |
| upd_ack | output | 1 | One-cycle pulse: the update is complete |
| src_ptr | output | 1 | Source-type bit of the fetched word 0, valid with `upd_ack` |
| chan_done | output | 1 | High with `upd_ack` when the channel finished |
| done_ch | output | 3 | Channel that the acknowledge refers to |
| mem_req | output | 1 | Memory access valid |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid while `mem_ready` is high |
| mem_ready | input | 1 | Access completes at this clock edge |

## Verification
The count update is exercised with four starting counts, each of which separates a different path:

- A mid-range count checks the plain decrement.
- A count of zero checks the wrap to 0xFFF and that the channel is not finished.
- A count of one with reload off checks a finish with no copy.
- A count of one with reload on checks the full copy sequence.

The words carry distinctive reserved and low fields and both source-type values. A scoreboard predicts every memory access in order, while the memory answers with stalls, so any wrong address, reordered copy step, altered field or extra access shows up. A request arriving mid-update and a write to the busy register show that ignored stimulus leaves both the memory traffic and the busy flags untouched.

// File: rtl/dma_desc_pkg.sv
package dma_desc_pkg;
    localparam int REC_BYTES  = 32;
    localparam int RELOAD_OFS = 16;
    localparam int WORD_BYTES = 4;
    localparam int TC_LSB     = 12;
    localparam int TC_W       = 12;
    localparam int SRC_BIT    = 11;

    localparam logic [1:0] RA_BASE   = 2'd0;
    localparam logic [1:0] RA_RELOAD = 2'd1;
    localparam logic [1:0] RA_BUSY   = 2'd2;

    typedef enum logic [2:0] {
        S_IDLE,
        S_FETCH,
        S_WBACK,
        S_RL_RD,
        S_RL_WR,
        S_REPORT
    } eng_state_t;
endpackage

// File: rtl/dma_desc_regs.sv
module dma_desc_regs
    import dma_desc_pkg::*;
#(
    parameter int          NUM_CH     = 8,
    parameter int          DATA_W     = 32,
    parameter int          ALIGN_BITS = 10,
    parameter logic [31:0] RST_BASE   = 32'h0008_0000,
    localparam int         CH_W       = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] base,
    output logic [NUM_CH-1:0] reload_en,
    input  logic              busy_set,
    input  logic              busy_clr,
    input  logic [CH_W-1:0]   busy_ch,
    output logic [NUM_CH-1:0] busy
);
    logic [DATA_W-ALIGN_BITS-1:0] base_hi_q;
    logic [NUM_CH-1:0]            reload_q;
    logic [NUM_CH-1:0]            busy_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_hi_q <= RST_BASE[DATA_W-1:ALIGN_BITS];
            reload_q  <= '0;
        end else if (wr) begin
            if (addr == RA_BASE)   base_hi_q <= wdata[DATA_W-1:ALIGN_BITS];
            if (addr == RA_RELOAD) reload_q  <= wdata[NUM_CH-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_q <= '0;
        end else begin
            if (busy_set) busy_q[busy_ch] <= 1'b1;
            if (busy_clr) busy_q[busy_ch] <= 1'b0;
        end
    end

    assign base      = {base_hi_q, {ALIGN_BITS{1'b0}}};
    assign reload_en = reload_q;
    assign busy      = busy_q;

    always_comb begin
        case (addr)
            RA_BASE:   rdata = base;
            RA_RELOAD: rdata = {{(DATA_W-NUM_CH){1'b0}}, reload_q};
            RA_BUSY:   rdata = {{(DATA_W-NUM_CH){1'b0}}, busy_q};
            default:   rdata = '0;
        endcase
    end

    // R8: an accepted request marks its channel busy
    a_r8_busy_set: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_set && !busy_clr) |=> busy_q[$past(busy_ch)]);
endmodule

// File: rtl/dma_desc_addr.sv
module dma_desc_addr
    import dma_desc_pkg::*;
#(
    parameter int  NUM_CH = 8,
    parameter int  ADDR_W = 32,
    localparam int CH_W   = $clog2(NUM_CH)
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [CH_W-1:0]   ch,
    input  logic              use_reload,
    input  logic [1:0]        word_idx,
    output logic [ADDR_W-1:0] addr
);
    logic [ADDR_W-1:0] rec_ofs;
    logic [ADDR_W-1:0] word_ofs;

    always_comb begin
        rec_ofs  = ADDR_W'(ch) * ADDR_W'(REC_BYTES);
        word_ofs = ADDR_W'(word_idx) * ADDR_W'(WORD_BYTES)
                 + (use_reload ? ADDR_W'(RELOAD_OFS) : '0);
        addr     = base + rec_ofs + word_ofs;
    end
endmodule

// File: rtl/dma_desc_tc.sv
module dma_desc_tc
    import dma_desc_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] word_in,
    output logic [DATA_W-1:0] word_out,
    output logic              last,
    output logic              src_ptr
);
    logic [TC_W-1:0] tc;
    logic [TC_W-1:0] tc_next;

    always_comb begin
        tc       = word_in[TC_LSB +: TC_W];
        tc_next  = tc - 1'b1;
        last     = (tc == TC_W'(1));
        src_ptr  = word_in[SRC_BIT];
        word_out = {word_in[DATA_W-1:TC_LSB+TC_W], tc_next, word_in[TC_LSB-1:0]};
    end
endmodule

// File: rtl/dma_desc_engine.sv
module dma_desc_engine
    import dma_desc_pkg::*;
#(
    parameter int          NUM_CH     = 8,
    parameter int          DATA_W     = 32,
    parameter int          ALIGN_BITS = 10,
    parameter logic [31:0] RST_BASE   = 32'h0008_0000,
    localparam int         CH_W       = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              upd_req,
    input  logic [CH_W-1:0]   upd_ch,
    output logic              eng_idle,
    output logic              upd_ack,
    output logic              src_ptr,
    output logic              chan_done,
    output logic [CH_W-1:0]   done_ch,
    output logic              mem_req,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ready
);
    eng_state_t        state_q, state_d;
    logic [CH_W-1:0]   ch_q;
    logic [DATA_W-1:0] w0_q;
    logic [DATA_W-1:0] cpy_q;
    logic [1:0]        k_q;

    logic [DATA_W-1:0] base;
    logic [NUM_CH-1:0] reload_en;
    logic [NUM_CH-1:0] busy;
    logic [DATA_W-1:0] wb_word;
    logic              last;
    logic              src_bit;
    logic              accept;
    logic              xfer_ok;
    logic              finish;
    logic [1:0]        widx;

    assign accept  = (state_q == S_IDLE) && upd_req;
    assign xfer_ok = mem_req && mem_ready;
    assign finish  = (state_q == S_REPORT) && last;

    dma_desc_regs #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .ALIGN_BITS(ALIGN_BITS),
                    .RST_BASE(RST_BASE)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .base(base),
        .reload_en(reload_en), .busy_set(accept), .busy_clr(finish),
        .busy_ch(accept ? upd_ch : ch_q), .busy(busy)
    );

    assign widx = (state_q == S_RL_RD || state_q == S_RL_WR) ? k_q : 2'd0;

    dma_desc_addr #(.NUM_CH(NUM_CH), .ADDR_W(DATA_W)) u_addr (
        .base(base), .ch(ch_q), .use_reload(state_q == S_RL_RD),
        .word_idx(widx), .addr(mem_addr)
    );

    dma_desc_tc #(.DATA_W(DATA_W)) u_tc (
        .word_in(w0_q), .word_out(wb_word), .last(last), .src_ptr(src_bit)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (accept) state_d = S_FETCH;
            S_FETCH:  if (xfer_ok) state_d = S_WBACK;
            S_WBACK:  if (xfer_ok) state_d = (last && reload_en[ch_q]) ? S_RL_RD : S_REPORT;
            S_RL_RD:  if (xfer_ok) state_d = S_RL_WR;
            S_RL_WR:  if (xfer_ok) state_d = (k_q == 2'd3) ? S_REPORT : S_RL_RD;
            S_REPORT: state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ch_q  <= '0;
            w0_q  <= '0;
            cpy_q <= '0;
            k_q   <= '0;
        end else begin
            if (accept) begin
                ch_q <= upd_ch;
                k_q  <= '0;
            end
            if (state_q == S_FETCH && xfer_ok) w0_q  <= mem_rdata;
            if (state_q == S_RL_RD && xfer_ok) cpy_q <= mem_rdata;
            if (state_q == S_RL_WR && xfer_ok) k_q   <= k_q + 2'd1;
        end
    end

    // outputs
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_wdata = '0;
        unique case (state_q)
            S_FETCH, S_RL_RD: mem_req = 1'b1;
            S_WBACK: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = wb_word;
            end
            S_RL_WR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = cpy_q;
            end
            default: ;
        endcase
        eng_idle  = (state_q == S_IDLE);
        upd_ack   = (state_q == S_REPORT);
        chan_done = finish;
        src_ptr   = src_bit;
        done_ch   = ch_q;
    end

    // R11: a stalled access keeps its request fields
    a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_we) &&
                                     $stable(mem_addr) && $stable(mem_wdata)));

    // R6: a finish is only flagged together with the acknowledge
    a_r6_done_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
        chan_done |-> upd_ack);

    // R10: a request while not idle leaves the selected channel alone
    a_r10_ignore_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (!eng_idle && upd_req) |=> $stable(ch_q));

    // R4: write-back keeps the fields around the count
    a_r4_fields_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_WBACK) |->
            (mem_wdata[DATA_W-1:TC_LSB+TC_W] == w0_q[DATA_W-1:TC_LSB+TC_W]) &&
            (mem_wdata[TC_LSB-1:0] == w0_q[TC_LSB-1:0]));

    // R7: the copy alternates read and write until word 3 is written
    a_r7_copy_order: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_RL_WR && xfer_ok && k_q != 2'd3) |=> (state_q == S_RL_RD));
endmodule

// File: tb/dma_desc_engine_tb.sv
module dma_desc_engine_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        upd_req = 1'b0;
    logic [2:0]  upd_ch = '0;
    logic        eng_idle, upd_ack, src_ptr, chan_done;
    logic [2:0]  done_ch;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        mem_ready = 1'b0;

    always #10 clk = ~clk;

    dma_desc_engine dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .upd_req(upd_req),
        .upd_ch(upd_ch), .eng_idle(eng_idle), .upd_ack(upd_ack),
        .src_ptr(src_ptr), .chan_done(chan_done), .done_ch(done_ch),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready)
    );

    typedef struct packed {
        logic        we;
        logic [31:0] addr;
        logic [31:0] data;
    } acc_t;

    acc_t        exp_q[$];
    logic [31:0] ram [0:1023];
    logic [31:0] base_m = 32'h0008_0000;
    logic [7:0]  rl_m = '0;
    int          checks = 0;
    int          fails = 0;
    int          cycles = 0;
    logic [1:0]  ph = '0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // memory model and monitor: stalls one cycle in three
    always @(negedge clk) begin
        ph = (ph == 2'd2) ? 2'd0 : ph + 2'd1;
        mem_ready = mem_req && (ph != 2'd0);
        if (mem_ready) begin
            if (mem_we) ram[mem_addr[11:2]] = mem_wdata;
            else        mem_rdata = ram[mem_addr[11:2]];
            if (exp_q.size() == 0) begin
                chk(1'b0, "R10 unexpected access", mem_addr, '0);
            end else begin
                acc_t e;
                e = exp_q.pop_front();
                chk(mem_we == e.we && mem_addr == e.addr, "R3/R7 access addr",
                    mem_addr, e.addr);
                if (e.we) chk(mem_wdata == e.data, "R4/R7 write data", mem_wdata, e.data);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            chk(1'b0, "watchdog", cycles, 20000);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic run_update(input int ch, input bit poke, input int poke_ch);
        logic [31:0] a, w, nw;
        logic [11:0] tc;
        bit          fin;
        int          n;
        a   = base_m + 32'(ch * 32);
        w   = ram[a[11:2]];
        tc  = w[23:12];
        fin = (tc == 12'd1);
        nw  = {w[31:24], tc - 12'd1, w[11:0]};
        exp_q.push_back('{1'b0, a, 32'h0});
        exp_q.push_back('{1'b1, a, nw});
        if (fin && rl_m[ch]) begin
            for (int k = 0; k < 4; k++) begin
                logic [31:0] ra;
                ra = a + 32'd16 + 32'(k * 4);
                exp_q.push_back('{1'b0, ra, 32'h0});
                exp_q.push_back('{1'b1, a + 32'(k * 4), ram[ra[11:2]]});
            end
        end
        @(negedge clk);
        upd_req = 1'b1; upd_ch = 3'(ch); reg_addr = 2'd2;
        @(negedge clk);
        #1;
        chk(reg_rdata[ch] == 1'b1, "R8 busy set on accept", reg_rdata, 32'(1 << ch));
        chk(eng_idle == 1'b0, "R10 not idle while working", eng_idle, 0);
        if (poke) upd_ch = 3'(poke_ch);
        else      upd_req = 1'b0;
        @(negedge clk);
        upd_req = 1'b0;
        #1;
        n = 0;
        while (!upd_ack && n < 200) begin
            @(negedge clk);
            #1;
            n++;
        end
        chk(upd_ack, "R6 ack seen", upd_ack, 1);
        chk(src_ptr == w[11], "R9 source type", src_ptr, w[11]);
        chk(chan_done == fin, "R5/R6 finish flag", chan_done, fin);
        if (fin) chk(done_ch == 3'(ch), "R6 done channel", done_ch, ch);
        @(negedge clk);
        #1;
        chk(eng_idle, "R10 idle after ack", eng_idle, 1);
        chk(exp_q.size() == 0, "R6/R7 all accesses done", exp_q.size(), 0);
        chk(reg_rdata[ch] == !fin, "R8 busy after update", reg_rdata[ch], !fin);
        if (poke) chk(reg_rdata[poke_ch] == 1'b0, "R10 poked channel idle",
                      reg_rdata[poke_ch], 0);
    endtask

    initial begin
        logic [31:0] r;
        for (int i = 0; i < 1024; i++) ram[i] = 32'(i) * 32'h0101_0101;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1
        rd_reg(2'd0, r); chk(r == 32'h0008_0000, "R1 base reset", r, 32'h0008_0000);
        rd_reg(2'd1, r); chk(r == 0, "R1 reload reset", r, 0);
        rd_reg(2'd2, r); chk(r == 0, "R1 busy reset", r, 0);
        chk(eng_idle, "R1 idle reset", eng_idle, 1);
        // R2
        wr_reg(2'd0, 32'h1234_5FFF);
        rd_reg(2'd0, r); chk(r == 32'h1234_5C00, "R2 base alignment", r, 32'h1234_5C00);
        base_m = 32'h1234_5C00;
        // R8 busy register read-only
        wr_reg(2'd2, 32'hFF);
        rd_reg(2'd2, r); chk(r == 0, "R8 busy read-only", r, 0);

        // R3 R4 R9: mid count, pointer source
        ram[(base_m[11:2]) + 2*8] = {8'hAB, 12'h005, 12'h8A5};
        run_update(2, 1'b0, 0);
        chk(ram[base_m[11:2] + 16] == {8'hAB, 12'h004, 12'h8A5}, "R4 stored word",
            ram[base_m[11:2] + 16], {8'hAB, 12'h004, 12'h8A5});
        // R5: zero count wraps
        ram[base_m[11:2] + 5*8] = {8'h11, 12'h000, 12'h3C4};
        run_update(5, 1'b0, 0);
        chk(ram[base_m[11:2] + 40][23:12] == 12'hFFF, "R5 wrap to FFF",
            ram[base_m[11:2] + 40], 32'h11FF_F3C4);
        // R6: finish without reload
        ram[base_m[11:2] + 3*8] = {8'h5A, 12'h001, 12'h0FF};
        run_update(3, 1'b0, 0);
        // R7: finish with reload on channel 7, R10 poke on channel 6
        wr_reg(2'd1, 32'h80); rl_m = 8'h80;
        rd_reg(2'd1, r); chk(r == 32'h80, "R7 reload enable", r, 32'h80);
        ram[base_m[11:2] + 56] = {8'hC3, 12'h001, 12'h800};
        for (int k = 0; k < 4; k++) ram[base_m[11:2] + 60 + k] = 32'hD00D_0000 + 32'(k);
        run_update(7, 1'b1, 6);
        for (int k = 0; k < 4; k++)
            chk(ram[base_m[11:2] + 56 + k] == 32'hD00D_0000 + 32'(k), "R7 active word reloaded",
                ram[base_m[11:2] + 56 + k], 32'hD00D_0000 + 32'(k));
        rd_reg(2'd2, r); chk(r == 32'h24, "R8 final busy flags", r, 32'h24);
        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R10 no stray access", exp_q.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule